// File: doc/BRIEF.md
# Configurable Decade Divider Counter

A four-bit counter built from two sections, each advanced by its own count pulse line: a divide-by-two stage that owns bit 0 and a divide-by-five stage that owns bits 3..1. A mode input chooses how the sections are chained inside the block. In decimal mode the external pulses enter the two-stage and its falling bit 0 advances the five-stage, so the outputs read as plain binary 0 to 9. In split-decade mode the pulses enter the five-stage and its falling bit 3 advances the two-stage, so bit 0 becomes a square wave at one tenth of the input rate with equal high and low halves.

Everything runs on one fast system clock. Each count line passes through a short synchronizer and a falling-edge detector, and the internal carry between sections is taken from the falling edge of the first section's registered bit. The carry therefore lands one system clock after the first section updates, which reproduces the ripple order without a derived clock. A one-cycle wrap strobe marks every return from nine to zero and can feed the count line of a second instance to divide by one hundred.

Top module: `decade_div_counter`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `q` is 4'b0000 and `wrap` is 0.
- R2: A section advances only on a high-to-low transition of its count source; a rising edge or a steady level, high or low, leaves `q` unchanged.
- R3: While `clr` is high, `q` is driven to 4'b0000 from the next clock on and held there; count edges arriving while `clr` is high, including one that lands in the same cycle as `clr` rises, leave no count behind once `clr` falls.
- R4: With `mode` = 0 (decimal), each falling edge on `cnt_a` steps `q` by one through 0..9 in plain binary and wraps 9 to 0.
- R5: With `mode` = 0, edges on `cnt_b` have no effect on `q`.
- R6: With `mode` = 1 (split-decade), after n falling edges on `cnt_b` since a clear, `q[3:1]` equals n mod 5 in binary and `q[0]` equals (n mod 10) div 5, so `q[0]` toggles whenever `q[3]` falls.
- R7: With `mode` = 1, edges on `cnt_a` have no effect on `q`.
- R8: The divide-by-five section never holds a value above 4; any value of 4 or more is replaced by 0 on its next advance.
- R9: `wrap` is high for exactly one clock each time the count returns from nine to zero, in either mode, and `q` reads 4'b0000 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Active-high master clear of all four bits |
| mode | input | 1 | 0 = decimal chaining, 1 = split-decade chaining |
| cnt_a | input | 1 | Count pulses for the divide-by-two section (falling edge) |
| cnt_b | input | 1 | Count pulses for the divide-by-five section (falling edge) |
| q | output | 4 | Counter bits; q[0] from the two-stage, q[3:1] from the five-stage |
| wrap | output | 1 | One-cycle strobe on the nine-to-zero wrap |

## Verification
A detected count edge and the master clear can land in the same clock, and so can the clear and the internal carry that follows a falling bit 0. The bench counts up to nine, drives a falling count line, and raises `clr` after a delay that is stepped from zero to five system clocks, so every stage of the synchronizer and carry path in turn meets the clear. Each case is judged by `q` reading zero while the clear is held and by a single later pulse giving exactly one, which shows that no half-finished carry survived the clear.

// File: rtl/dd_pkg.sv
package dd_pkg;
  typedef enum logic {
    MODE_DEC   = 1'b0,
    MODE_SPLIT = 1'b1
  } dd_mode_e;

  localparam int unsigned QUIN_W   = 3;
  localparam int unsigned QUIN_TOP = 4;
endpackage

// File: rtl/dd_fall_det.sv
module dd_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign fall = prev_q & ~sync_q[LAST];

  // R2: a detected edge is a single-cycle strobe
  a_r2_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/dd_div2.sv
module dd_div2 (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (adv)   q <= ~q;
  end

  // R2: no advance, no change
  a_r2_div2_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(q));
endmodule

// File: rtl/dd_div5.sv
module dd_div5 #(
  parameter int unsigned W   = 3,
  parameter int unsigned TOP = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP_V = W'(TOP);

  logic [W-1:0] nxt;

  always_comb begin
    if (q >= TOP_V) nxt = '0;
    else            nxt = q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (adv)   q <= nxt;
  end

  // R8: value stays within 0..TOP
  a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
    q <= TOP_V);
  // R2: no advance, no change
  a_r2_div5_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(q));
endmodule

// File: rtl/decade_div_counter.sv
module decade_div_counter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       mode,
  input  logic       cnt_a,
  input  logic       cnt_b,
  output logic [3:0] q,
  output logic       wrap
);
  import dd_pkg::*;

  localparam int unsigned QW    = QUIN_W;
  localparam int unsigned MSB   = QW - 1;
  localparam logic [QW-1:0] TOPV = QW'(QUIN_TOP);

  dd_mode_e    md;
  logic        fall_a, fall_b;
  logic        adv2, adv5;
  logic        bit0;
  logic [QW-1:0] hi;
  logic        bit0_d, msb_d;
  logic        bit0_fall, msb_fall;
  logic        wrap_q;

  assign md = dd_mode_e'(mode);

  dd_fall_det #(.STAGES(SYNC_STAGES)) u_det_a (
    .clk(clk), .rst(rst), .din(cnt_a), .fall(fall_a));
  dd_fall_det #(.STAGES(SYNC_STAGES)) u_det_b (
    .clk(clk), .rst(rst), .din(cnt_b), .fall(fall_b));

  // internal carry: falling edge of the first section's registered bit
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bit0_d <= 1'b0;
      msb_d  <= 1'b0;
    end else begin
      bit0_d <= bit0;
      msb_d  <= hi[MSB];
    end
  end

  assign bit0_fall = bit0_d & ~bit0;
  assign msb_fall  = msb_d  & ~hi[MSB];

  always_comb begin
    if (md == MODE_DEC) begin
      adv2 = fall_a;
      adv5 = bit0_fall;
    end else begin
      adv2 = msb_fall;
      adv5 = fall_b;
    end
  end

  dd_div2 u_two (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv2), .q(bit0));

  dd_div5 #(.W(QW), .TOP(QUIN_TOP)) u_five (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv5), .q(hi));

  always_ff @(posedge clk) begin
    if (rst || clr)          wrap_q <= 1'b0;
    else if (md == MODE_DEC) wrap_q <= adv5 && (hi == TOPV);
    else                     wrap_q <= adv2 && bit0;
  end

  assign q    = {hi, bit0};
  assign wrap = wrap_q;

  // R3: clear empties the counter on the next clock
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == 4'd0));
  // R9: wrap coincides with a zero count
  a_r9_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (q == 4'd0));
  // R9: wrap lasts one clock
  a_r9_wrap_single: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);
  // R4: decimal mode never shows a code above nine
  a_r4_dec_range: assert property (@(posedge clk) disable iff (rst)
    (md == MODE_DEC) |-> (q <= 4'd9));
endmodule

// File: tb/decade_div_counter_tb.sv
module decade_div_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       mode = 1'b0;
  logic       cnt_a = 1'b1;
  logic       cnt_b = 1'b1;
  logic [3:0] q;
  logic       wrap;

  typedef struct {
    logic [3:0] val;
    int         due;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   wrap_cycles = 0;
  int   wrap_rises = 0;
  logic wrap_prev = 1'b0;
  bit   done = 1'b0;

  decade_div_counter u_dut (
    .clk(clk), .rst(rst), .clr(clr), .mode(mode),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .q(q), .wrap(wrap));

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t it;
    if (exp_q.size() > 0 && cyc >= exp_q[0].due) begin
      it = exp_q.pop_front();
      check(q == it.val, it.tag, int'(q), int'(it.val));
    end
    if (!rst) begin
      if (wrap) wrap_cycles++;
      if (wrap && !wrap_prev) wrap_rises++;
    end
    wrap_prev = wrap;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(int sel, logic v);
    if (sel == 0) cnt_a = v;
    else          cnt_b = v;
  endtask

  task automatic pulse(int sel);
    drive(sel, 1'b0);
    wait_cyc(4);
    drive(sel, 1'b1);
    wait_cyc(4);
  endtask

  task automatic expect_q(logic [3:0] v, string tag);
    exp_t it;
    it.val = v;
    it.due = cyc + 2;
    it.tag = tag;
    exp_q.push_back(it);
    wait_cyc(4);
  endtask

  task automatic clear_to(logic m);
    clr = 1'b1;
    mode = m;
    wait_cyc(3);
    clr = 1'b0;
    wait_cyc(2);
    wrap_cycles = 0;
    wrap_rises = 0;
  endtask

  function automatic logic [3:0] dec_ref(int n);
    return 4'(n % 10);
  endfunction

  function automatic logic [3:0] split_ref(int n);
    int c;
    c = n % 10;
    return {3'(c % 5), 1'(c / 5)};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_up();
  end

  initial begin
    wait_cyc(5);
    check(q == 4'd0, "R1 q during reset", int'(q), 0);
    check(wrap == 1'b0, "R1 wrap during reset", int'(wrap), 0);
    rst = 1'b0;
    wait_cyc(1);
    check(q == 4'd0, "R1 q after reset", int'(q), 0);

    // R4: decimal counting and wrap
    clear_to(1'b0);
    for (int n = 1; n <= 23; n++) begin
      pulse(0);
      expect_q(dec_ref(n), "R4 decimal step");
    end
    check(wrap_rises == 2, "R9 decimal wrap count", wrap_rises, 2);
    check(wrap_cycles == 2, "R9 decimal wrap width", wrap_cycles, 2);

    // R5: cnt_b ignored in decimal mode
    pulse(1);
    pulse(1);
    expect_q(4'd3, "R5 cnt_b ignored");

    // R2: falling edge counts, steady low and rising edge do not
    drive(0, 1'b0);
    wait_cyc(12);
    expect_q(4'd4, "R2 falling edge counts");
    wait_cyc(10);
    expect_q(4'd4, "R2 steady low no change");
    drive(0, 1'b1);
    wait_cyc(10);
    expect_q(4'd4, "R2 rising edge no change");

    // R3: clear with a count in flight, and edges during clear
    drive(0, 1'b0);
    wait_cyc(3);
    clr = 1'b1;
    wait_cyc(6);
    expect_q(4'd0, "R3 clear mid-count");
    drive(0, 1'b1);
    pulse(0);
    pulse(0);
    expect_q(4'd0, "R3 edges under clear");
    clr = 1'b0;
    wait_cyc(4);
    expect_q(4'd0, "R3 nothing left after clear");
    pulse(0);
    expect_q(4'd1, "R3 counts resume");

    // R3: clear meets edge/carry at each stage of the path
    for (int d = 0; d < 6; d++) begin
      clear_to(1'b0);
      for (int k = 0; k < 9; k++) pulse(0);
      expect_q(4'd9, "R4 reached nine");
      drive(0, 1'b0);
      wait_cyc(d);
      clr = 1'b1;
      wait_cyc(8);
      expect_q(4'd0, "R3 clear collides with count");
      drive(0, 1'b1);
      wait_cyc(4);
      clr = 1'b0;
      wait_cyc(4);
      pulse(0);
      expect_q(4'd1, "R3 single count after collision");
    end

    // R6: split-decade counting
    clear_to(1'b1);
    for (int n = 1; n <= 23; n++) begin
      pulse(1);
      expect_q(split_ref(n), "R6 split step");
    end
    check(wrap_rises == 2, "R9 split wrap count", wrap_rises, 2);
    check(wrap_cycles == 2, "R9 split wrap width", wrap_cycles, 2);

    // R7: cnt_a ignored in split mode (count 3 -> q 0110)
    pulse(0);
    pulse(0);
    expect_q(split_ref(23), "R7 cnt_a ignored");

    wait_cyc(4);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule